// File: doc/BRIEF.md
# Dual-Edge Capture Register

This block is a register of parameterised width that takes a new value from its data input at every transition of its clock, rising and falling alike. It is assembled only from ordinary flops that each respond to a single clock edge. There are two such storage cells per bit: one updates on the rising transition and the other on the falling transition. The output always shows the value sampled at the most recent transition.

A compile-time parameter chooses how each bit is built. The toggle structure keeps a parity pair: each cell flips its state only when the input and the present output disagree, and the output is the XOR of the two cells. Because of this, an edge whose sampled input already equals the output leaves the output untouched. The multiplexer structure captures the input directly into both cells. The clock level then steers which cell drives the output. This structure cannot be upset by runt clock pulses, but it may glitch briefly at an edge. Every bit is an independent copy. An active-low asynchronous reset clears all storage.

Top module: `dual_edge_reg`

## Requirements
- R1: While `rst_n` is 0, `dout` is all zeros in both structures, asynchronously and independent of clock activity.
- R2: After each rising edge of `clk`, `dout` equals the `din` value sampled at that rising edge.
- R3: After each falling edge of `clk`, `dout` equals the `din` value sampled at that falling edge.
- R4: Between two clock edges `dout` holds its value, whatever `din` does.
- R5: With the toggle structure, an edge at which the sampled `din` equals the current `dout` causes no change at all on `dout`.
- R6: `STYLE` = `DE_XOR_TOGGLE` (encoding 0) selects the toggle structure, and `DE_CLOCK_MUX` (encoding 1) selects the multiplexer structure. Sampled away from the edges, both structures give the same `dout`.
- R7: Each bit of `dout` depends only on the same bit of `din`. Bit patterns that differ per bit are captured exactly.
- R8: The first edge after `rst_n` returns to 1 captures `din` normally. This can be a rising or a falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; both transitions capture |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | W | Data to be captured |
| dout | output | W | Most recently captured data |

## Verification
The assertions check on every cycle that the output seen half a period after each edge matches the input shadow-captured at that edge, in both structures. They also check that the toggle structure leaves its output untouched across an edge at which input and output already agreed, and that reset forces zero. Only the bench scenarios can show the following: the output stays steady while the input moves between edges, the bits are independent, capture restarts cleanly after a reset released mid-run, and the two structures agree on random traffic. For R5 the bench also counts output transitions directly, because the zero-width glitch of the multiplexer structure is invisible to sampled properties.

// File: rtl/dual_edge_pkg.sv
package dual_edge_pkg;

    // Selects the per-bit storage structure.
    typedef enum logic {
        DE_XOR_TOGGLE = 1'b0,
        DE_CLOCK_MUX  = 1'b1
    } de_style_e;

    // Next values of the two storage cells of one bit.
    typedef struct packed {
        logic rise;
        logic fall;
    } de_pair_t;

endpackage

// File: rtl/de_cell_xor.sv
module de_cell_xor
    import dual_edge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic     rise_q;
    logic     fall_q;
    logic     tog;
    de_pair_t nxt_d;

    always_comb begin
        q          = rise_q ^ fall_q;
        tog        = q ^ d;
        nxt_d.rise = rise_q ^ tog;
        nxt_d.fall = fall_q ^ tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= 1'b0;
        else        rise_q <= nxt_d.rise;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= nxt_d.fall;
    end

    // Shadows for the no-change check: was input equal to output at the edge,
    // and what did the output show just before it.
    logic match_r_q, prev_r_q, seen_r_q;
    logic match_f_q, prev_f_q, seen_f_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_r_q <= 1'b0;
            prev_r_q  <= 1'b0;
            seen_r_q  <= 1'b0;
        end else begin
            match_r_q <= (d == q);
            prev_r_q  <= q;
            seen_r_q  <= 1'b1;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_f_q <= 1'b0;
            prev_f_q  <= 1'b0;
            seen_f_q  <= 1'b0;
        end else begin
            match_f_q <= (d == q);
            prev_f_q  <= q;
            seen_f_q  <= 1'b1;
        end
    end

    // R5: a rising edge with matching input leaves the output as it was
    a_r5_hold_rise: assert property (@(negedge clk) disable iff (!rst_n)
        (seen_r_q && match_r_q) |-> (q == prev_r_q));

    // R5: a falling edge with matching input leaves the output as it was
    a_r5_hold_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_f_q && match_f_q) |-> (q == prev_f_q));

endmodule

// File: rtl/de_cell_mux.sv
module de_cell_mux
    import dual_edge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic     rise_q;
    logic     fall_q;
    de_pair_t nxt_d;

    always_comb begin
        nxt_d.rise = d;
        nxt_d.fall = d;
        // Clock high: rising-edge cell holds the latest sample; low: falling-edge cell.
        q          = clk ? rise_q : fall_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= 1'b0;
        else        rise_q <= nxt_d.rise;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= nxt_d.fall;
    end

endmodule

// File: rtl/dual_edge_reg.sv
module dual_edge_reg
    import dual_edge_pkg::*;
#(
    parameter int        W     = 1,
    parameter de_style_e STYLE = DE_XOR_TOGGLE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    localparam int LAST = W - 1;

    for (genvar b = 0; b <= LAST; b++) begin : g_bit
        if (STYLE == DE_XOR_TOGGLE) begin : g_xor
            de_cell_xor u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (din[b]),
                .q     (dout[b])
            );
        end else begin : g_mux
            de_cell_mux u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (din[b]),
                .q     (dout[b])
            );
        end
    end

    // Shadow captures of the input at each edge type, used only by the checks.
    logic [W-1:0] shadow_r_q, shadow_f_q;
    logic         seen_r_q, seen_f_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_r_q <= '0;
            seen_r_q   <= 1'b0;
        end else begin
            shadow_r_q <= din;
            seen_r_q   <= 1'b1;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_f_q <= '0;
            seen_f_q   <= 1'b0;
        end else begin
            shadow_f_q <= din;
            seen_f_q   <= 1'b1;
        end
    end

    // R1: reset forces a zero output (this property is about reset itself)
    a_r1_reset_zero: assert property (@(posedge clk)
        (!rst_n) |-> (dout == '0));

    // R2: half a period after a rising edge the output shows that edge's sample
    a_r2_rise_capture: assert property (@(negedge clk) disable iff (!rst_n)
        seen_r_q |-> (dout == shadow_r_q));

    // R3: half a period after a falling edge the output shows that edge's sample
    a_r3_fall_capture: assert property (@(posedge clk) disable iff (!rst_n)
        seen_f_q |-> (dout == shadow_f_q));

endmodule

// File: tb/dual_edge_reg_bench.sv
module dual_edge_reg_bench;
    import dual_edge_pkg::*;

    localparam int W = 8;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b1;
    logic [W-1:0] din   = '0;
    logic [W-1:0] dout_x, dout_m;
    logic [W-1:0] model;

    int  n_tests   = 0;
    int  n_fail    = 0;
    int  n_changes = 0;
    bit  mon_en    = 1'b0;
    bit  done      = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    dual_edge_reg #(.W(W), .STYLE(DE_XOR_TOGGLE)) u_dual_edge_reg (
        .clk(clk), .rst_n(rst_n), .din(din), .dout(dout_x));

    dual_edge_reg #(.W(W), .STYLE(DE_CLOCK_MUX)) u_dual_edge_reg_mux (
        .clk(clk), .rst_n(rst_n), .din(din), .dout(dout_m));

    // Reference: capture on every transition, clear on reset.
    always @(posedge clk or negedge clk or negedge rst_n) begin
        if (!rst_n) model <= '0;
        else        model <= din;
    end

    // Transition counter for the toggle structure output (R5).
    always @(dout_x) if (mon_en) n_changes++;

    // {stimulus, expected}
    localparam logic [2*W-1:0] VEC [12] = '{
        {8'h5A, 8'h5A}, {8'hA5, 8'hA5}, {8'h01, 8'h01}, {8'h80, 8'h80},
        {8'hFF, 8'hFF}, {8'h00, 8'h00}, {8'h0F, 8'h0F}, {8'hF0, 8'hF0},
        {8'h3C, 8'h3C}, {8'hC3, 8'hC3}, {8'h69, 8'h69}, {8'h96, 8'h96}
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Drive v before an edge, check after it, disturb din and check hold.
    task automatic step(input logic [W-1:0] v, input logic [W-1:0] exp);
        din = v;
        @(clk);
        #1;
        if (clk) begin
            chk("R2 xor", dout_x, exp);
            chk("R2 mux", dout_m, exp);
        end else begin
            chk("R3 xor", dout_x, exp);
            chk("R3 mux", dout_m, exp);
        end
        #1 din = ~v;
        #1;
        chk("R4 xor hold", dout_x, exp);
        chk("R4 mux hold", dout_m, exp);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        #1 rst_n = 1'b0;
        din = 8'hFF;
        #2;
        chk("R1 xor reset", dout_x, '0);
        chk("R1 mux reset", dout_m, '0);
        repeat (3) @(clk);
        #2;
        chk("R1 xor reset with clock", dout_x, '0);
        chk("R1 mux reset with clock", dout_m, '0);

        // R8: release off-edge; first edge captures
        @(negedge clk) #2 rst_n = 1'b1;
        din = 8'h3A;
        @(clk) #1;
        chk("R8 xor first edge", dout_x, 8'h3A);
        chk("R8 mux first edge", dout_m, 8'h3A);
        #2;

        // Table walk: R2, R3, R4 and per-bit patterns for R7
        for (int i = 0; i < 12; i++) begin
            step(VEC[i][2*W-1:W], VEC[i][W-1:0]);
        end

        // R7: one bit moves while the others stay
        step(8'h96, 8'h96);
        step(8'h97, 8'h97);
        chk("R7 xor single bit", dout_x, 8'h97);
        chk("R7 mux single bit", dout_m, 8'h97);

        // R5: din equal to dout across several edges causes no transition
        din = 8'h97;
        n_changes = 0;
        mon_en = 1'b1;
        repeat (4) @(clk);
        #2;
        mon_en = 1'b0;
        n_tests++;
        if (n_changes != 0) begin
            n_fail++;
            $display("FAIL R5 actual=%0d expected=0 transitions", n_changes);
        end
        chk("R5 xor value", dout_x, 8'h97);
        chk("R5 mux value", dout_m, 8'h97);

        // Random traffic vs reference model; R6 both structures agree
        for (int k = 0; k < 200; k++) begin
            din = W'($urandom);
            @(clk) #1;
            chk(clk ? "R2 xor random" : "R3 xor random", dout_x, model);
            chk("R6 mux matches xor", dout_m, dout_x);
            #2;
        end

        // R1 mid-run: asynchronous reset between edges
        din = 8'hC7;
        @(clk) #2 rst_n = 1'b0;
        #1;
        chk("R1 xor async mid-run", dout_x, '0);
        chk("R1 mux async mid-run", dout_m, '0);
        @(posedge clk) #2 rst_n = 1'b1;
        din = 8'h5C;
        @(clk) #1;
        chk("R8 xor after mid reset (falling)", dout_x, 8'h5C);
        chk("R8 mux after mid reset (falling)", dout_m, 8'h5C);

        done = 1'b1;
        finish_run();
    end

endmodule